// File: doc/BRIEF.md
# Dual-Channel DAC Data Controller

This block is the digital front end of a two-channel converter with 12-bit codes. Software reaches it through a simple 32-bit register bus. The bus uses a write strobe and returns read data combinationally. Each channel keeps a holding register and an output register. The output register drives the code port of an external converter. New codes can be written in three alignments, either per channel or packed for both channels in one write.

The holding value moves to the output register in one of two ways. When the channel's trigger is off, it moves right away. When the trigger is on, it moves on a selected event: a rising edge on one of several hardware trigger lines, or a self-clearing software trigger bit.

A hardware trigger can also raise a per-channel DMA request. The request is held until the DMA engine acknowledges it. If another hardware trigger arrives while the request is still open, the channel sets a sticky underrun flag. The flag is cleared by writing 1 to it, and it can drive the interrupt line.

Top module: `dac_ctrl_core`

## Requirements
- R1: After reset, every register reads 0, both code outputs are 0, and `dma_req` and `irq` are low.
- R2: Channel A has a holding window at 0x08 and channel B one at 0x14. Inside a window, offset +0 takes a 12-bit right-aligned code from bits [11:0]. Offset +4 takes a left-aligned code from bits [15:4]. Offset +8 takes an 8-bit code from bits [7:0] into code bits [11:4], with code bits [3:0] cleared. A read of 0x08 or 0x14 returns that channel's holding code in bits [11:0].
- R3: A write to the packed window at 0x20 loads both channels in one write. The +0 and +4 formats take channel A from the low half-word and channel B from the high half-word, using the same bit ranges as R2. The +8 format takes channel A from bits [7:0] and channel B from bits [15:8].
- R4: Reads of 0x2C and 0x30 return the output codes of A and B, which equal `code_a` and `code_b`. Writes to these addresses change nothing.
- R5: While a channel's trigger enable is 0, its output register takes the holding value on the clock edge after the holding register loads.
- R6: The control register is at 0x00. Channel A owns bits [15:0] and channel B owns bits [31:16]. Inside each half: bit 0 is enable, bit 2 is trigger enable, bits [5:3] select the trigger (0 to 6 select `hw_trig` lines, 7 selects software), bit 12 is DMA enable and bit 13 is underrun interrupt enable. With enable and trigger enable set, a rising edge on the selected line (low at edge k-1, high at edge k) loads the output at edge k+1. Edges on other lines do nothing, and holding a line high gives only one load.
- R7: The software trigger register is at 0x04. Bit 0 is channel A and bit 1 is channel B. Writing a 1 at edge k to an armed channel (select 7) loads its output at edge k+2, and the bit reads 0 from then on. Writing 3 triggers both channels together.
- R8: With DMA enable set, a hardware trigger sets `dma_req` on the same edge that loads the output. `dma_ack` clears the request. A software trigger never raises a request.
- R9: A hardware trigger that reaches the DMA logic while the request is high and `dma_ack` is low sets the channel's underrun flag. If `dma_ack` is high in that same cycle, no underrun is flagged and the request stays high.
- R10: The status register is at 0x34. Bit 13 is the channel A underrun flag and bit 29 is channel B's. Writing 1 to a flag clears it, and writing 0 leaves it as it is. `irq` is high when any flag is set together with its interrupt enable.
- R11: While a channel's enable bit is set, control writes leave its trigger select unchanged. The other fields still update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| hw_trig | input | 7 | Hardware trigger lines, rising-edge sensitive |
| dma_ack | input | 2 | Per-channel DMA acknowledge |
| dma_req | output | 2 | Per-channel DMA request |
| irq | output | 1 | Underrun interrupt |
| code_a | output | 12 | Channel A output code |
| code_b | output | 12 | Channel B output code |

## Verification
The request path can see a new hardware trigger and an acknowledge of the old request in the same cycle. The bench provokes this by raising `dma_ack` in the cycle right after a trigger pulse, which is the cycle the registered event reaches the DMA logic. It then checks that the request stays high and that the underrun flag stays clear. A second trigger sent without an acknowledge must set the flag. The same check is repeated with the interrupt enable off, where `irq` must stay low.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
   // register byte offsets
   localparam logic [7:0] OFS_CTRL = 8'h00;
   localparam logic [7:0] OFS_SWT  = 8'h04;
   localparam logic [7:0] OFS_WINA = 8'h08;
   localparam logic [7:0] OFS_WINB = 8'h14;
   localparam logic [7:0] OFS_WIND = 8'h20;
   localparam logic [7:0] OFS_OUTA = 8'h2C;
   localparam logic [7:0] OFS_OUTB = 8'h30;
   localparam logic [7:0] OFS_STAT = 8'h34;

   // field positions inside one 16-bit channel lane
   localparam int B_EN  = 0;
   localparam int B_TEN = 2;
   localparam int B_SEL = 3;
   localparam int B_DMA = 12;
   localparam int B_UIE = 13;
   localparam int B_UDR = 13;

   typedef enum logic [1:0] {
      FMT_R12  = 2'd0,
      FMT_L12  = 2'd1,
      FMT_R8   = 2'd2,
      FMT_NONE = 2'd3
   } fmt_e;
endpackage

// File: rtl/dac_hold_decode.sv
module dac_hold_decode
   import dac_ctrl_pkg::*;
#(
   parameter int CODE_W = 12
) (
   input  logic              we,
   input  logic [7:0]        addr,
   input  logic [31:0]       wdata,
   output logic [1:0]        ld,
   output logic [CODE_W-1:0] val_a,
   output logic [CODE_W-1:0] val_b
);
   localparam int NWIN = 3;
   localparam int NFMT = 3;
   localparam logic [7:0] WIN_BASE [NWIN] = '{OFS_WINA, OFS_WINB, OFS_WIND};

   fmt_e        fmt;
   logic        dual;
   logic [15:0] lane_a, lane_b;

   function automatic logic [CODE_W-1:0] fit(input logic [15:0] lane, input fmt_e f);
      case (f)
         FMT_L12: fit = lane[15 -: CODE_W];
         FMT_R8:  fit = {lane[7:0], {(CODE_W-8){1'b0}}};
         default: fit = lane[CODE_W-1:0];
      endcase
   endfunction

   always_comb begin
      ld   = '0;
      fmt  = FMT_NONE;
      dual = 1'b0;
      for (int w = 0; w < NWIN; w++) begin
         for (int f = 0; f < NFMT; f++) begin
            if (we && addr == WIN_BASE[w] + 8'(4*f)) begin
               fmt  = fmt_e'(2'(f));
               dual = (w == NWIN-1);
               ld   = (w == NWIN-1) ? 2'b11 : 2'(1 << w);
            end
         end
      end
   end

   always_comb begin
      lane_a = wdata[15:0];
      if (!dual)              lane_b = wdata[15:0];
      else if (fmt == FMT_R8) lane_b = {8'h00, wdata[15:8]};
      else                    lane_b = wdata[31:16];
   end

   assign val_a = fit(lane_a, fmt);
   assign val_b = fit(lane_b, fmt);
endmodule

// File: rtl/dac_chan.sv
module dac_chan
   import dac_ctrl_pkg::*;
#(
   parameter int CODE_W = 12,
   parameter int NSRC   = 7,
   parameter int SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [15:0]       ctrl_wd,
   input  logic              sw_set,
   input  logic              st_clr,
   input  logic              dhr_we,
   input  logic [CODE_W-1:0] dhr_wval,
   input  logic [NSRC-1:0]   hw_trig,
   input  logic              dma_ack,
   output logic [15:0]       ctrl_q,
   output logic              sw_q,
   output logic              evt_hw_q,
   output logic              evt_sw_q,
   output logic              udr_q,
   output logic [CODE_W-1:0] dhr_q,
   output logic [CODE_W-1:0] dor_q,
   output logic              dma_req
);
   localparam int NSEL = 1 << SEL_W;
   localparam logic [SEL_W-1:0] SW_CODE = SEL_W'(NSEL-1);
   localparam logic [15:0] SEL_MASK   = 16'(((1 << SEL_W) - 1) << B_SEL);
   localparam logic [15:0] FIELD_MASK = SEL_MASK | (16'd1 << B_EN) | (16'd1 << B_TEN)
                                      | (16'd1 << B_DMA) | (16'd1 << B_UIE);

   logic              en, ten, dma_en, armed, sw_armed, hw_fire, sw_fire, udr_set;
   logic [SEL_W-1:0]  sel;
   logic [NSRC-1:0]   hw_q;
   logic [NSEL-1:0]   rise_pad;
   logic [15:0]       ctrl_next;

   assign en       = ctrl_q[B_EN];
   assign ten      = ctrl_q[B_TEN];
   assign dma_en   = ctrl_q[B_DMA];
   assign sel      = ctrl_q[B_SEL +: SEL_W];
   assign armed    = en & ten;
   assign sw_armed = armed & (sel == SW_CODE);

   always_comb begin
      rise_pad = '0;
      rise_pad[NSRC-1:0] = hw_trig & ~hw_q;
   end

   assign hw_fire = armed & (sel != SW_CODE) & rise_pad[sel];
   assign sw_fire = sw_q & sw_armed & ~evt_sw_q;
   assign udr_set = evt_hw_q & dma_en & dma_req & ~dma_ack;

   // select field is frozen while the channel is enabled
   assign ctrl_next = (ctrl_wd & FIELD_MASK & ~SEL_MASK)
                    | (en ? (ctrl_q & SEL_MASK) : (ctrl_wd & SEL_MASK));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         sw_q     <= 1'b0;
         hw_q     <= '0;
         evt_hw_q <= 1'b0;
         evt_sw_q <= 1'b0;
         udr_q    <= 1'b0;
         dhr_q    <= '0;
         dor_q    <= '0;
         dma_req  <= 1'b0;
      end else begin
         hw_q     <= hw_trig;
         evt_hw_q <= hw_fire;
         evt_sw_q <= sw_fire;
         if (ctrl_we) ctrl_q <= ctrl_next;
         if (sw_set)                       sw_q <= 1'b1;
         else if (evt_sw_q || !sw_armed)   sw_q <= 1'b0;
         if (dhr_we) dhr_q <= dhr_wval;
         if (!ten || evt_hw_q || evt_sw_q) dor_q <= dhr_q;
         udr_q <= udr_set | (udr_q & ~st_clr);
         if (evt_hw_q && dma_en) dma_req <= 1'b1;
         else if (dma_ack)       dma_req <= 1'b0;
      end
   end
endmodule

// File: rtl/dac_ctrl_core.sv
module dac_ctrl_core
   import dac_ctrl_pkg::*;
#(
   parameter int CODE_W = 12,
   parameter int NSRC   = 7,
   parameter int SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [7:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NSRC-1:0]   hw_trig,
   input  logic [1:0]        dma_ack,
   output logic [1:0]        dma_req,
   output logic              irq,
   output logic [CODE_W-1:0] code_a,
   output logic [CODE_W-1:0] code_b
);
   localparam int NCH = 2;

   if (CODE_W < 9 || CODE_W > 16) begin : g_bad_code_w
      $error("CODE_W must lie in 9..16");
   end
   if (NSRC < 1 || NSRC > (1 << SEL_W) - 1) begin : g_bad_nsrc
      $error("NSRC must leave the top select code for software");
   end
   if (B_SEL + SEL_W > B_DMA) begin : g_bad_sel_w
      $error("select field overlaps DMA enable");
   end

   logic [1:0]            dhr_ld;
   logic [CODE_W-1:0]     val_a, val_b;
   logic [15:0]           ctrl_v [NCH];
   logic [NCH-1:0]        sw_v, evt_hw_v, evt_sw_v, udr_v, st_clr_v, en_v, ten_v, uie_v;
   logic [NCH*SEL_W-1:0]  sel_v;
   logic [NCH*CODE_W-1:0] dhr_v, dor_v;
   logic                  ctrl_we, swt_we, stat_we;

   assign ctrl_we = bus_we && bus_addr == OFS_CTRL;
   assign swt_we  = bus_we && bus_addr == OFS_SWT;
   assign stat_we = bus_we && bus_addr == OFS_STAT;

   dac_hold_decode #(.CODE_W(CODE_W)) u_dec (
      .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .ld(dhr_ld), .val_a(val_a), .val_b(val_b)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic [CODE_W-1:0] dhr_i, dor_i;
      assign st_clr_v[i] = stat_we & bus_wdata[16*i + B_UDR];
      dac_chan #(.CODE_W(CODE_W), .NSRC(NSRC), .SEL_W(SEL_W)) u_chan (
         .clk(clk), .rst_n(rst_n),
         .ctrl_we(ctrl_we), .ctrl_wd(bus_wdata[16*i +: 16]),
         .sw_set(swt_we & bus_wdata[i]), .st_clr(st_clr_v[i]),
         .dhr_we(dhr_ld[i]), .dhr_wval(i == 0 ? val_a : val_b),
         .hw_trig(hw_trig), .dma_ack(dma_ack[i]),
         .ctrl_q(ctrl_v[i]), .sw_q(sw_v[i]),
         .evt_hw_q(evt_hw_v[i]), .evt_sw_q(evt_sw_v[i]),
         .udr_q(udr_v[i]), .dhr_q(dhr_i), .dor_q(dor_i),
         .dma_req(dma_req[i])
      );
      assign dhr_v[i*CODE_W +: CODE_W] = dhr_i;
      assign dor_v[i*CODE_W +: CODE_W] = dor_i;
      assign en_v[i]  = ctrl_v[i][B_EN];
      assign ten_v[i] = ctrl_v[i][B_TEN];
      assign uie_v[i] = ctrl_v[i][B_UIE];
      assign sel_v[i*SEL_W +: SEL_W] = ctrl_v[i][B_SEL +: SEL_W];
   end

   assign code_a = dor_v[0 +: CODE_W];
   assign code_b = dor_v[CODE_W +: CODE_W];
   assign irq    = |(udr_v & uie_v);

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_CTRL: bus_rdata = {ctrl_v[1], ctrl_v[0]};
         OFS_SWT:  bus_rdata = {30'b0, sw_v};
         OFS_WINA: bus_rdata[CODE_W-1:0] = dhr_v[0 +: CODE_W];
         OFS_WINB: bus_rdata[CODE_W-1:0] = dhr_v[CODE_W +: CODE_W];
         OFS_OUTA: bus_rdata[CODE_W-1:0] = code_a;
         OFS_OUTB: bus_rdata[CODE_W-1:0] = code_b;
         OFS_STAT: begin
            bus_rdata[B_UDR]      = udr_v[0];
            bus_rdata[16 + B_UDR] = udr_v[1];
         end
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/dac_ctrl_chk.sv
module dac_ctrl_chk #(
   parameter int CODE_W = 12,
   parameter int SEL_W  = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [1:0]            dma_req,
   input logic [1:0]            dma_ack,
   input logic [1:0]            evt_hw,
   input logic [1:0]            evt_sw,
   input logic [1:0]            udr,
   input logic [1:0]            st_clr,
   input logic [1:0]            en,
   input logic [1:0]            ten,
   input logic [2*SEL_W-1:0]    sel,
   input logic [2*CODE_W-1:0]   dhr,
   input logic [2*CODE_W-1:0]   dor
);
   for (genvar i = 0; i < 2; i++) begin : g_c
      // R5
      imm_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(!ten[i]) |-> dor[i*CODE_W +: CODE_W] == $past(dhr[i*CODE_W +: CODE_W]));
      // R6
      trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(ten[i] && !evt_hw[i] && !evt_sw[i]) |-> $stable(dor[i*CODE_W +: CODE_W]));
      // R8
      dma_hw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(dma_req[i]) |-> $past(evt_hw[i]));
      // R9
      udr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(udr[i]) |-> $past(evt_hw[i] && dma_req[i] && !dma_ack[i]));
      // R10
      udr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(udr[i]) |-> $past(st_clr[i]));
      // R11
      sel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(en[i]) |-> $stable(sel[i*SEL_W +: SEL_W]));
   end
endmodule

bind dac_ctrl_core dac_ctrl_chk #(.CODE_W(CODE_W), .SEL_W(SEL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .dma_ack(dma_ack),
   .evt_hw(evt_hw_v), .evt_sw(evt_sw_v), .udr(udr_v), .st_clr(st_clr_v),
   .en(en_v), .ten(ten_v), .sel(sel_v), .dhr(dhr_v), .dor(dor_v)
);

// File: tb/dac_ctrl_core_test.sv
`timescale 1ns/100ps
module dac_ctrl_core_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [6:0]  hw_trig = '0;
   logic [1:0]  dma_ack = '0;
   logic [1:0]  dma_req;
   logic        irq;
   logic [11:0] code_a, code_b;
   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   dac_ctrl_core uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_trig(hw_trig),
      .dma_ack(dma_ack), .dma_req(dma_req), .irq(irq),
      .code_a(code_a), .code_b(code_b)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.3;
      d = bus_rdata;
   endtask

   task automatic pulse_hw(input int i);
      @(negedge clk); hw_trig[i] = 1'b1;
      @(negedge clk); hw_trig[i] = 1'b0;
      @(negedge clk);
   endtask

   function automatic logic [11:0] fmt_code(input logic [15:0] lane, input int f);
      if (f == 0)      return lane[11:0];
      else if (f == 1) return lane[15:4];
      else             return {lane[7:0], 4'h0};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] r, d;
      logic [11:0] ea, eb;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 code_a", {20'b0, code_a}, 0);
      check("R1 code_b", {20'b0, code_b}, 0);
      check("R1 dma/irq", {29'b0, dma_req, irq}, 0);
      rd(8'h00, r); check("R1 ctrl", r, 0);
      rd(8'h04, r); check("R1 swt", r, 0);
      rd(8'h34, r); check("R1 stat", r, 0);

      // R2 / R5 single windows, immediate transfer
      ea = 12'h0; eb = 12'h0;
      for (int c = 0; c < 2; c++) begin
         for (int f = 0; f < 3; f++) begin
            for (int v = 0; v < 16; v++) begin
               d = (32'(v) * 32'h9E37_79B1) ^ 32'(f << 9) ^ 32'(c << 13);
               wr((c == 0 ? 8'h08 : 8'h14) + 8'(4*f), d);
               if (v == 0) check("R5 not yet", {20'b0, c == 0 ? code_a : code_b}, {20'b0, c == 0 ? ea : eb});
               @(negedge clk);
               if (c == 0) ea = fmt_code(d[15:0], f); else eb = fmt_code(d[15:0], f);
               check("R2 code", {20'b0, c == 0 ? code_a : code_b}, {20'b0, c == 0 ? ea : eb});
               rd(c == 0 ? 8'h08 : 8'h14, r);
               check("R2 hold read", r, {20'b0, c == 0 ? ea : eb});
            end
         end
      end
      check("R5 other chan kept", {20'b0, code_a}, {20'b0, ea});

      // R3 packed window
      for (int f = 0; f < 3; f++) begin
         for (int v = 0; v < 16; v++) begin
            d = (32'(v + 1) * 32'h6C8E_9CF5) ^ 32'(f << 20);
            wr(8'h20 + 8'(4*f), d);
            @(negedge clk);
            ea = fmt_code(d[15:0], f);
            eb = (f == 2) ? {d[15:8], 4'h0} : fmt_code(d[31:16], f);
            check("R3 code_a", {20'b0, code_a}, {20'b0, ea});
            check("R3 code_b", {20'b0, code_b}, {20'b0, eb});
            // R4 readback
            rd(8'h2C, r); check("R4 out A", r, {20'b0, ea});
            rd(8'h30, r); check("R4 out B", r, {20'b0, eb});
         end
      end
      wr(8'h2C, 32'hFFFF_FFFF);
      wr(8'h30, 32'h1234_5678);
      @(negedge clk);
      check("R4 ro A", {20'b0, code_a}, {20'b0, ea});
      check("R4 ro B", {20'b0, code_b}, {20'b0, eb});

      // R6 hardware trigger: A on line 2, B on line 5
      wr(8'h00, {16'h002D, 16'h0015});
      wr(8'h08, 32'h0000_0123);
      @(negedge clk); @(negedge clk);
      check("R6 no trig hold", {20'b0, code_a}, {20'b0, ea});
      pulse_hw(5);
      check("R6 wrong line", {20'b0, code_a}, {20'b0, ea});
      check("R6 B line 5", {20'b0, code_b}, {20'b0, eb});
      @(negedge clk); hw_trig[2] = 1'b1;
      @(negedge clk);
      check("R6 edge k", {20'b0, code_a}, {20'b0, ea});
      @(negedge clk);
      check("R6 edge k+1", {20'b0, code_a}, 32'h123);
      wr(8'h08, 32'h0000_0789);
      @(negedge clk); @(negedge clk);
      check("R6 level no retrigger", {20'b0, code_a}, 32'h123);
      hw_trig[2] = 1'b0;
      pulse_hw(2);
      check("R6 second edge", {20'b0, code_a}, 32'h789);

      // R11 select lock
      wr(8'h00, {16'h002D, 16'h0024});
      rd(8'h00, r); check("R11 sel kept", r, {16'h002D, 16'h0014});
      wr(8'h00, {16'h002D, 16'h0024});
      rd(8'h00, r); check("R11 sel taken when off", r, {16'h002D, 16'h0024});

      // R7 software trigger
      wr(8'h00, {16'h0000, 16'h003C});
      wr(8'h00, {16'h003C, 16'h003D});
      wr(8'h00, {16'h003D, 16'h003D});
      rd(8'h00, r); check("R7 ctrl", r, {16'h003D, 16'h003D});
      wr(8'h20, 32'h00CD_00AB);
      @(negedge clk); @(negedge clk);
      check("R7 held A", {20'b0, code_a}, 32'h789);
      wr(8'h04, 32'h3);
      rd(8'h04, r); check("R7 bits set", r, 3);
      @(negedge clk);
      check("R7 k+1 A", {20'b0, code_a}, 32'h789);
      @(negedge clk);
      check("R7 k+2 A", {20'b0, code_a}, 32'h0AB);
      check("R7 k+2 B", {20'b0, code_b}, 32'h0CD);
      rd(8'h04, r); check("R7 self clear", r, 0);
      wr(8'h08, 32'h0000_0555);
      wr(8'h04, 32'h1);
      @(negedge clk); @(negedge clk);
      check("R7 single A", {20'b0, code_a}, 32'h555);
      check("R7 single B kept", {20'b0, code_b}, 32'h0CD);

      // R8 DMA: A on line 2 with DMA and irq enable; B software with DMA
      wr(8'h00, {16'h303D, 16'h0000});
      wr(8'h00, {16'h303D, 16'h3015});
      wr(8'h04, 32'h2);
      repeat (3) @(negedge clk);
      check("R8 no req on sw", {30'b0, dma_req}, 0);
      wr(8'h08, 32'h0000_0321);
      pulse_hw(2);
      check("R8 req set", {30'b0, dma_req}, 2'b01);
      check("R8 load with req", {20'b0, code_a}, 32'h321);
      @(negedge clk); dma_ack[0] = 1'b1;
      @(negedge clk); dma_ack[0] = 1'b0;
      check("R8 ack clears", {30'b0, dma_req}, 0);

      // R9 underrun
      pulse_hw(2);
      pulse_hw(2);
      rd(8'h34, r); check("R9 udr set", r, 32'h0000_2000);
      check("R10 irq", {31'b0, irq}, 1);
      check("R9 req held", {30'b0, dma_req}, 2'b01);
      wr(8'h34, 32'h0);
      rd(8'h34, r); check("R10 write 0 keeps", r, 32'h0000_2000);
      wr(8'h34, 32'h0000_2000);
      rd(8'h34, r); check("R10 w1c", r, 0);
      check("R10 irq low", {31'b0, irq}, 0);
      // same-cycle trigger and ack
      @(negedge clk); hw_trig[2] = 1'b1;
      @(negedge clk); hw_trig[2] = 1'b0; dma_ack[0] = 1'b1;
      @(negedge clk); dma_ack[0] = 1'b0;
      rd(8'h34, r); check("R9 ack same cycle no udr", r, 0);
      check("R9 ack same cycle req", {30'b0, dma_req}, 2'b01);
      // masked interrupt
      wr(8'h00, {16'h303D, 16'h1015});
      pulse_hw(2);
      rd(8'h34, r); check("R10 masked udr", r, 32'h0000_2000);
      check("R10 masked irq", {31'b0, irq}, 0);
      wr(8'h34, 32'h0000_2000);
      @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule